// File: doc/BRIEF.md
# Ring-Oscillator Challenge Sequencer

This block drives the selection side of a ring-oscillator fingerprint array. The oscillators are arranged as a grid of tiles, `COLS` tiles wide and `ROWS` tiles tall, and each tile holds four oscillators. On every comparison cycle the block names four oscillators. The first and second form one pair, which compares oscillators sitting in different slots. The third and fourth form a second pair, which compares the same slot in two different tiles. The two pairs are measured in parallel by logic outside this block.

All four indices come from a single base counter plus fixed offsets. A spacing term, added in multiples of one tile (four indices), sets how far apart the oscillators of a pair are. In the nearby option the spacing is zero. In the remote option it is half the tile count. The block also decodes the four indices into row and column enables, so that only the selected oscillators run.

A run begins with a start strobe. The start strobe clears the base counter and captures the nearby/remote option for the whole run. An advance strobe then moves the challenge on by one.

Top module: `roc_challenge_seq`

## Requirements
- R1: After reset, no run is active: `row_en` and `col_en` are all zero, `sel_a` is 0 and the nearby offsets apply (`sel_b`=1, `sel_c`=2, `sel_d`=6).
- R2: A clock edge with `run_start` high sets the base index `sel_a` to 0, marks the run active and captures `far_mode` as the spacing choice.
- R3: In an active run, a clock edge with `step` high (and `run_start` low) advances `sel_a` by one modulo 4·COLS·ROWS. Without `step`, `sel_a` holds its value.
- R4: At all times `sel_b = sel_a + 1 + 4·s`, `sel_c = sel_a + 2` and `sel_d = sel_a + 6 + 4·s`, each taken modulo 4·COLS·ROWS, where s is the spacing term.
- R5: The spacing term s is 0 when the captured option is nearby (`far_mode`=0) and COLS·ROWS/2 when it is remote (`far_mode`=1).
- R6: Changes on `far_mode` during a run have no effect on the selects until the next `run_start`.
- R7: When `run_start` and `step` are high on the same edge, the start wins and `sel_a` becomes 0.
- R8: Index encoding: slot = index mod 4, tile = index / 4, tile column = tile mod COLS, tile row = tile / COLS. COLS must be a power of two.
- R9: During an active run, bit r of `row_en` is set exactly when one of the four selects lies in tile row r. Bit 4·c+p of `col_en` is set exactly when one of them lies in tile column c with slot p. All other enable bits are 0.
- R10: `step` has no effect before the first `run_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Begin a run: clear the base index and capture the spacing option |
| step | input | 1 | Advance to the next challenge |
| far_mode | input | 1 | Spacing option: 0 nearby, 1 remote |
| sel_a | output | $clog2(4·COLS·ROWS) | First oscillator index (base counter) |
| sel_b | output | $clog2(4·COLS·ROWS) | Partner of `sel_a`, different slot |
| sel_c | output | $clog2(4·COLS·ROWS) | First oscillator of the same-slot pair |
| sel_d | output | $clog2(4·COLS·ROWS) | Partner of `sel_c`, same slot in another tile |
| row_en | output | ROWS | Tile-row enables |
| col_en | output | 4·COLS | Enables per tile column and slot |

## Verification
The start of a run and the advance of the counter can fall on the same edge, and the base counter can wrap on that same edge. The bench drives `run_start` and `step` together, both in the middle of a run and on the last index, and expects index 0 with the newly captured spacing. A cycle-by-cycle integer model of the base, the spacing and the active flag predicts the four selects and both enable vectors after every edge. The model also covers toggling `far_mode` mid-run, which must leave the selects unchanged.

// File: rtl/roc_pkg.sv
package roc_pkg;

  // Sum of two values already below the modulus, folded back once.
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

  // Offsets of the four selects, expressed in units of one index.
  function automatic int unsigned tile_stride(input int unsigned spc);
    return 4 * spc;
  endfunction

  localparam int unsigned OFS_A = 0;
  localparam int unsigned OFS_B = 1;
  localparam int unsigned OFS_C = 2;
  localparam int unsigned OFS_D = 6;

endpackage

// File: rtl/roc_base_ctr.sv
module roc_base_ctr #(
  parameter int unsigned N_OSC = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             step,
  input  logic             far_mode,
  output logic [IDX_W-1:0] base,
  output logic             far_q,
  output logic             active,
  output logic             adv,
  output logic             wrap_pt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_OSC - 1);

  // start has priority over advance
  assign adv     = step & active & ~run_start;
  assign wrap_pt = adv & (base == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      far_q  <= 1'b0;
      active <= 1'b0;
    end else if (run_start) begin
      base   <= '0;
      far_q  <= far_mode;
      active <= 1'b1;
    end else if (adv) begin
      base <= wrap_pt ? '0 : base + 1'b1;
    end
  end

endmodule

// File: rtl/roc_sel_calc.sv
module roc_sel_calc
  import roc_pkg::*;
#(
  parameter int unsigned N_TILE = 16,
  parameter int unsigned IDX_W  = 6
) (
  input  logic             far_q,
  input  logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] sel_a,
  output logic [IDX_W-1:0] sel_b,
  output logic [IDX_W-1:0] sel_c,
  output logic [IDX_W-1:0] sel_d
);
  localparam int unsigned N_OSC   = 4 * N_TILE;
  localparam int unsigned SPC_FAR = N_TILE / 2;

  int unsigned spc;
  int unsigned b32;

  always_comb begin
    spc   = far_q ? SPC_FAR : 0;
    b32   = int'(base);
    sel_a = IDX_W'(wrap_add(b32, OFS_A, N_OSC));
    sel_b = IDX_W'(wrap_add(b32, OFS_B + tile_stride(spc), N_OSC));
    sel_c = IDX_W'(wrap_add(b32, OFS_C, N_OSC));
    sel_d = IDX_W'(wrap_add(b32, OFS_D + tile_stride(spc), N_OSC));
  end

endmodule

// File: rtl/roc_enable_dec.sv
module roc_enable_dec #(
  parameter int unsigned COLS  = 4,
  parameter int unsigned ROWS  = 4,
  parameter int unsigned IDX_W = 6
) (
  input  logic                       active,
  input  logic [3:0][IDX_W-1:0]      sels,
  output logic [ROWS-1:0]            row_en,
  output logic [4*COLS-1:0]          col_en
);
  localparam int unsigned CW = $clog2(COLS);
  localparam int unsigned TW = IDX_W - 2;

  logic [3:0][ROWS-1:0]   row_oh;
  logic [3:0][4*COLS-1:0] col_oh;

  for (genvar k = 0; k < 4; k++) begin : g_sel
    logic [TW-1:0] tile;
    logic [CW-1:0] tcol;
    logic [TW-1:0] trow;
    logic [1:0]    slot;
    assign slot = sels[k][1:0];
    assign tile = sels[k][IDX_W-1:2];
    assign tcol = tile[CW-1:0];
    assign trow = tile >> CW;
    assign row_oh[k] = active ? (ROWS'(1) << trow) : '0;
    assign col_oh[k] = active ? ((4*COLS)'(1) << {tcol, slot}) : '0;
  end

  always_comb begin
    row_en = '0;
    col_en = '0;
    for (int k = 0; k < 4; k++) begin
      row_en = row_en | row_oh[k];
      col_en = col_en | col_oh[k];
    end
  end

endmodule

// File: rtl/roc_challenge_seq.sv
module roc_challenge_seq #(
  parameter  int unsigned COLS  = 4,
  parameter  int unsigned ROWS  = 4,
  localparam int unsigned IDX_W = $clog2(4 * COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic              step,
  input  logic              far_mode,
  output logic [IDX_W-1:0]  sel_a,
  output logic [IDX_W-1:0]  sel_b,
  output logic [IDX_W-1:0]  sel_c,
  output logic [IDX_W-1:0]  sel_d,
  output logic [ROWS-1:0]   row_en,
  output logic [4*COLS-1:0] col_en
);
  localparam int unsigned N_TILE = COLS * ROWS;
  localparam int unsigned N_OSC  = 4 * N_TILE;

  logic [IDX_W-1:0] base;
  logic             far_q;
  logic             active;
  logic             adv;
  logic             wrap_pt;

  roc_base_ctr #(.N_OSC(N_OSC), .IDX_W(IDX_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_start(run_start),
    .step     (step),
    .far_mode (far_mode),
    .base     (base),
    .far_q    (far_q),
    .active   (active),
    .adv      (adv),
    .wrap_pt  (wrap_pt)
  );

  roc_sel_calc #(.N_TILE(N_TILE), .IDX_W(IDX_W)) u_calc (
    .far_q(far_q),
    .base (base),
    .sel_a(sel_a),
    .sel_b(sel_b),
    .sel_c(sel_c),
    .sel_d(sel_d)
  );

  roc_enable_dec #(.COLS(COLS), .ROWS(ROWS), .IDX_W(IDX_W)) u_dec (
    .active(active),
    .sels  ({sel_d, sel_c, sel_b, sel_a}),
    .row_en(row_en),
    .col_en(col_en)
  );

endmodule

// File: rtl/roc_checker.sv
module roc_checker #(
  parameter  int unsigned COLS  = 4,
  parameter  int unsigned ROWS  = 4,
  localparam int unsigned IDX_W = $clog2(4 * COLS * ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_start,
  input logic              step,
  input logic              active,
  input logic              far_q,
  input logic              wrap_pt,
  input logic [IDX_W-1:0]  sel_a,
  input logic [IDX_W-1:0]  sel_b,
  input logic [IDX_W-1:0]  sel_c,
  input logic [IDX_W-1:0]  sel_d,
  input logic [ROWS-1:0]   row_en,
  input logic [4*COLS-1:0] col_en
);
  localparam int NO  = 4 * COLS * ROWS;
  localparam int SPF = 4 * ((COLS * ROWS) / 2);

  function automatic int md(input int v);
    return v % NO;
  endfunction

  int spc4;
  assign spc4 = far_q ? SPF : 0;

  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (sel_a == '0) && active);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !run_start) |=> int'(sel_a) == md(int'($past(sel_a)) + 1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !run_start) |=> $stable(sel_a));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pt |=> sel_a == '0);

  a_r4_third: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_c) == md(int'(sel_a) + 2));

  a_r5_second: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_b) == md(int'(sel_a) + 1 + spc4));

  a_r5_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_d) == md(int'(sel_a) + 6 + spc4));

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> $stable(far_q));

  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(row_en) <= 4) && ($countones(col_en) <= 4));

  a_r9_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (row_en == '0) && (col_en == '0));

  a_r10_no_early_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !run_start) |=> !active);

endmodule

bind roc_challenge_seq roc_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_start(run_start),
  .step     (step),
  .active   (active),
  .far_q    (far_q),
  .wrap_pt  (wrap_pt),
  .sel_a    (sel_a),
  .sel_b    (sel_b),
  .sel_c    (sel_c),
  .sel_d    (sel_d),
  .row_en   (row_en),
  .col_en   (col_en)
);

// File: tb/sim_roc_challenge_seq.sv
`timescale 1ns/1ps
module sim_roc_challenge_seq;
  localparam int COLS = 4;
  localparam int ROWS = 4;
  localparam int NT   = COLS * ROWS;
  localparam int NO   = 4 * NT;
  localparam int W    = $clog2(NO);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start = 1'b0;
  logic step = 1'b0;
  logic far_mode = 1'b0;
  logic [W-1:0] sel_a, sel_b, sel_c, sel_d;
  logic [ROWS-1:0] row_en;
  logic [4*COLS-1:0] col_en;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_base   = 0;
  int m_far    = 0;
  int m_active = 0;

  always #2 clk = ~clk;

  roc_challenge_seq #(.COLS(COLS), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .step(step),
    .far_mode(far_mode), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .sel_d(sel_d), .row_en(row_en), .col_en(col_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int idx[4];
    int er = 0;
    int ec = 0;
    int gap = (m_far != 0) ? 4 * (NT / 2) : 0;
    idx[0] = m_base;
    idx[1] = (m_base + 1 + gap) % NO;
    idx[2] = (m_base + 2) % NO;
    idx[3] = (m_base + 6 + gap) % NO;
    if (m_active != 0) begin
      foreach (idx[k]) begin
        int t = idx[k] / 4;
        er = er | (1 << (t / COLS));                   // R8 row = tile / COLS
        ec = ec | (1 << ((t % COLS) * 4 + idx[k] % 4)); // R8 column/slot bit
      end
    end
    check(req, "sel_a (R3)", int'(sel_a), idx[0]);
    check(req, "sel_b (R4/R5)", int'(sel_b), idx[1]);
    check(req, "sel_c (R4)", int'(sel_c), idx[2]);
    check(req, "sel_d (R4/R5)", int'(sel_d), idx[3]);
    check(req, "row_en (R9)", int'(row_en), er);
    check(req, "col_en (R9)", int'(col_en), ec);
  endtask

  // drive at the negedge, let the edge act, compare at the next negedge
  task automatic tick(input bit s, input bit st, input bit f, input string req);
    run_start = s;
    step      = st;
    far_mode  = f;
    @(posedge clk);
    if (s) begin
      m_base = 0; m_far = f; m_active = 1;
    end else if (st && m_active != 0) begin
      m_base = (m_base + 1) % NO;
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset state");

    // R10: advance requests before any run
    for (int i = 0; i < 3; i++) tick(0, 1, 1, "R10 step before run");

    // R2 nearby run, walk past the wrap (R3)
    tick(1, 0, 0, "R2 start nearby");
    for (int i = 0; i < NO + 5; i++) tick(0, 1, 0, "R3 nearby advance");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, "R3 hold without step");

    // R6: option toggled mid-run
    for (int i = 0; i < 6; i++) tick(0, i % 2, 1, "R6 far_mode ignored mid-run");

    // R5 remote run
    tick(1, 0, 1, "R5 start remote");
    for (int i = 0; i < NO + 3; i++) tick(0, 1, (i % 3) == 0, "R5 remote advance");

    // R7: start and step together mid-run, then on the last index
    tick(1, 1, 0, "R7 start+step mid-run");
    for (int i = 0; i < NO - 1; i++) tick(0, 1, 1, "R3 climb to last index");
    tick(1, 1, 1, "R7 start+step at wrap");
    for (int i = 0; i < 10; i++) tick(0, (i % 3) != 0, 0, "R4 mixed stepping");

    // R1 again after a second reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_base = 0; m_far = 0; m_active = 0;
    @(negedge clk);
    compare_all("R1 reset mid-run");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule